// File: doc/BRIEF.md
# Image sensor line and frame readout sequencer

This block sequences the readout of one frame of an area image sensor, one line at a time, on a single system clock. A frame-start input rearms the frame: it clears the line counter and copies the programmed pixel and line totals into the working copies used for the frame. A line-clock pulse starts each line. While the line clock stays high, the sequencer is held and does not advance. Once the line clock drops, a fixed row-blanking interval runs, and then the pixels of the line are counted out.

The block reports each pixel slot with a pixel-valid strobe and a pixel index. It gives a one-cycle end-of-line marker just after pixel-valid falls. When the line that completes the programmed line total has been read, it also raises end-of-frame. The totals are written through a plain parallel write port. A write lands in staging registers, which are used only from the next frame start. The outputs carry no data payload and accept no back-pressure: pixel-valid has no ready partner, and a downstream consumer must take every valid cycle as it comes.

Top module: `readout_seq`

## Requirements
- R1: After reset, pix_valid, eol and eof are 0, and line_index is 0. Until the first frame start, the working pixel and line totals are the parameters DEF_PIX and DEF_LINES.
- R2: A line clock sampled high outside readout suspends the sequencer. Blanking starts with the first edge at which line_clk is sampled low. If line_clk is sampled high again during blanking, blanking starts over after the next fall.
- R3: The first edge at which line_clk is sampled low is edge 0. After edge BLANK_CYC, pix_valid is high for exactly P cycles, where P is the working pixel total, and pix_index steps from 0 to P-1.
- R4: line_index is 0 in the cycle after frame_start is sampled high. It rises by one in the same cycle that pix_valid falls at the end of a line.
- R5: eol is a single-cycle pulse. It is high in the second cycle after the last cycle in which pix_valid is high, that is, one cycle after pix_valid falls.
- R6: eof is high in the same cycle as eol exactly when the completed line makes line_index equal to the working line total. On any other line it stays 0, including lines read past the total.
- R7: A cfg_we write during a frame has no effect on the current frame. The new totals are used from the next frame start on.
- R8: frame_start must be held for at least 3 cycles. While it is high, the sequencer goes idle, which aborts any line in progress without an eol.
- R9: A line-clock pulse that arrives while pixels are read out, or in the cycle after, is ignored. It is flagged by a cover point in simulation.
- R10: The programmed pixel total and line total must both be at least 1. A total of 1 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the rising edge is the only active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame rearm level; must be held at least 3 cycles |
| line_clk | input | 1 | Line start; holding it high suspends the sequencer |
| cfg_we | input | 1 | Write strobe for the staging totals |
| cfg_pix_total | input | PIX_W | Pixels per line to stage (at least 1) |
| cfg_line_total | input | LINE_W | Lines per frame to stage (at least 1) |
| pix_valid | output | 1 | High for each pixel slot of the current line |
| pix_index | output | PIX_W | Index of the current pixel, meaningful while pix_valid is high |
| eol | output | 1 | End-of-line pulse, one cycle after pix_valid falls |
| eof | output | 1 | End-of-frame pulse, coincident with the eol of the last line |
| line_index | output | LINE_W | Number of lines completed since the last frame start |

## Verification
The checker takes three things for granted about the inputs. frame_start stays high for at least three cycles. Both staged totals are non-zero. No line clock arrives in the same cycle as frame_start. The checker enforces the frame-start width itself with a run-length counter. A line clock during readout is not treated as an error: it only hits a cover point, so the ignore behaviour can be exercised. The stimulus holds frame_start for exactly three cycles and writes only totals of at least one. It raises line_clk only while frame_start is low, and deliberately pokes the line clock during readout in one scenario.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_BLANK = 3'd2,
    ST_READ  = 3'd3,
    ST_TAIL  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rs_counter.sv
// Up counter with synchronous clear taking priority over increment.
module rs_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rs_cfg_bank.sv
// Staging totals written at any time; working totals copied on commit.
module rs_cfg_bank #(
  parameter int PIX_W     = 12,
  parameter int LINE_W    = 12,
  parameter int DEF_PIX   = 16,
  parameter int DEF_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIX_W-1:0]  wr_pix,
  input  logic [LINE_W-1:0] wr_lines,
  input  logic              commit,
  output logic [PIX_W-1:0]  act_pix,
  output logic [LINE_W-1:0] act_lines
);
  localparam logic [PIX_W-1:0]  PIX_RST  = PIX_W'(DEF_PIX);
  localparam logic [LINE_W-1:0] LINE_RST = LINE_W'(DEF_LINES);

  logic [PIX_W-1:0]  stg_pix;
  logic [LINE_W-1:0] stg_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_pix   <= PIX_RST;
      stg_lines <= LINE_RST;
    end else if (wr_en) begin
      stg_pix   <= wr_pix;
      stg_lines <= wr_lines;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pix   <= PIX_RST;
      act_lines <= LINE_RST;
    end else if (commit) begin
      act_pix   <= stg_pix;
      act_lines <= stg_lines;
    end
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int PIX_W     = 12,
  parameter int LINE_W    = 12,
  parameter int BLANK_CYC = 8,
  parameter int DEF_PIX   = 16,
  parameter int DEF_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_clk,
  input  logic              cfg_we,
  input  logic [PIX_W-1:0]  cfg_pix_total,
  input  logic [LINE_W-1:0] cfg_line_total,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_index,
  output logic              eol,
  output logic              eof,
  output logic [LINE_W-1:0] line_index
);
  import rs_pkg::*;

  localparam int              BLK_W    = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLANK_CYC - 1);

  seq_state_e        state_q, state_d;
  logic [PIX_W-1:0]  act_pix;
  logic [LINE_W-1:0] act_lines;
  logic [BLK_W-1:0]  blk_cnt;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              last_pix;
  logic              eol_q, eof_q;

  rs_cfg_bank #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .DEF_PIX(DEF_PIX), .DEF_LINES(DEF_LINES)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
    .wr_pix(cfg_pix_total), .wr_lines(cfg_line_total),
    .commit(frame_start), .act_pix(act_pix), .act_lines(act_lines)
  );

  assign last_pix = (pix_cnt == act_pix - PIX_W'(1));

  // Blanking timer: held at zero outside blanking and whenever the line clock is high.
  rs_counter #(.W(BLK_W)) u_blank (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_BLANK || line_clk || frame_start),
    .inc(state_q == ST_BLANK),
    .cnt(blk_cnt)
  );

  rs_counter #(.W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_READ || frame_start),
    .inc(state_q == ST_READ),
    .cnt(pix_cnt)
  );

  rs_counter #(.W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .clr(frame_start),
    .inc(state_q == ST_READ && last_pix),
    .cnt(line_cnt)
  );

  always_comb begin
    state_d = state_q;
    if (frame_start) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (line_clk) state_d = ST_HOLD;
        ST_HOLD:  if (!line_clk) state_d = ST_BLANK;
        ST_BLANK: begin
          if (line_clk)                  state_d = ST_HOLD;
          else if (blk_cnt == BLK_LAST)  state_d = ST_READ;
        end
        ST_READ:  if (last_pix) state_d = ST_TAIL;
        ST_TAIL:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eol_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eol_q   <= (state_q == ST_TAIL);
      eof_q   <= (state_q == ST_TAIL) && (line_cnt == act_lines);
    end
  end

  assign pix_valid  = (state_q == ST_READ);
  assign pix_index  = pix_cnt;
  assign eol        = eol_q;
  assign eof        = eof_q;
  assign line_index = line_cnt;
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_clk,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  pix_index,
  input logic              eol,
  input logic              eof,
  input logic [LINE_W-1:0] line_index,
  input logic [PIX_W-1:0]  act_pix,
  input logic [LINE_W-1:0] act_lines
);
  logic [1:0] fs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fs_run <= '0;
    else if (!frame_start) fs_run <= '0;
    else if (fs_run != 2'd3) fs_run <= fs_run + 2'd1;
  end

  a_r2_hold_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clk && !pix_valid) |=> !pix_valid);

  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_index < act_pix));

  a_r4_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_index == '0));

  a_r5_eol_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> (!$past(pix_valid) && $past(pix_valid, 2)));

  a_r5_eol_single: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> !eol);

  a_r6_eof_with_eol: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol);

  a_r6_eof_at_total: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !$past(frame_start)) |-> (line_index == act_lines));

  a_r8_fs_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_start) |-> (fs_run == 2'd3));

  // R9: a line clock during readout is legal but noted.
  c_r9_lineclk_in_read: cover property (@(posedge clk) disable iff (!rst_n)
    pix_valid && line_clk);
endmodule

bind readout_seq readout_seq_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_clk(line_clk),
  .pix_valid(pix_valid), .pix_index(pix_index), .eol(eol), .eof(eof),
  .line_index(line_index), .act_pix(act_pix), .act_lines(act_lines)
);

// File: tb/readout_seq_tb.sv
`timescale 1ns/1ps
module readout_seq_tb;
  localparam int PW = 12;
  localparam int LW = 12;
  localparam int B  = 8;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, line_clk = 0, cfg_we = 0;
  logic [PW-1:0] cfg_pix_total = '0;
  logic [LW-1:0] cfg_line_total = '0;
  logic pix_valid, eol, eof;
  logic [PW-1:0] pix_index;
  logic [LW-1:0] line_index;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  readout_seq #(.PIX_W(PW), .LINE_W(LW), .BLANK_CYC(B), .DEF_PIX(6), .DEF_LINES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_clk(line_clk),
    .cfg_we(cfg_we), .cfg_pix_total(cfg_pix_total), .cfg_line_total(cfg_line_total),
    .pix_valid(pix_valid), .pix_index(pix_index), .eol(eol), .eof(eof),
    .line_index(line_index)
  );

  task automatic check(bit ok, string req, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic write_cfg(int p, int l);
    @(negedge clk);
    cfg_we = 1; cfg_pix_total = PW'(p); cfg_line_total = LW'(l);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1;
    repeat (3) @(negedge clk);
    frame_start = 0;
    check(line_index == 0, "R4", $sformatf("line_index after frame start act=%0d exp=0", line_index));
  endtask

  // Run one line; samples at negedges n=1.. after line_clk is released.
  task automatic run_line(int hold, int p, bit last, int exp_line, int poke, string tag);
    int e_pv = 0, e_eol = 0, e_eof = 0;
    string m_pv = "", m_eol = "", m_eof = "";
    @(negedge clk);
    line_clk = 1;
    repeat (hold) @(negedge clk);
    line_clk = 0;
    for (int n = 1; n <= B + p + 3; n++) begin
      bit x_pv, x_eol, x_eof;
      @(negedge clk);
      x_pv  = (n >= B + 1) && (n <= B + p);
      x_eol = (n == B + p + 2);
      x_eof = x_eol && last;
      if (pix_valid !== x_pv || (x_pv && pix_index != PW'(n - B - 1))) begin
        if (e_pv == 0) m_pv = $sformatf("n=%0d pv act=%0b exp=%0b idx act=%0d exp=%0d",
                                        n, pix_valid, x_pv, pix_index, n - B - 1);
        e_pv++;
      end
      if (eol !== x_eol) begin
        if (e_eol == 0) m_eol = $sformatf("n=%0d eol act=%0b exp=%0b", n, eol, x_eol);
        e_eol++;
      end
      if (eof !== x_eof) begin
        if (e_eof == 0) m_eof = $sformatf("n=%0d eof act=%0b exp=%0b", n, eof, x_eof);
        e_eof++;
      end
      if (n == B + p + 2)
        check(line_index == LW'(exp_line), "R4",
              $sformatf("%s line_index act=%0d exp=%0d", tag, line_index, exp_line));
      if (poke != 0 && n == poke) line_clk = 1;
      else if (poke != 0 && n == poke + 1) line_clk = 0;
    end
    check(e_pv == 0,  "R3", {tag, " ", m_pv});
    check(e_eol == 0, "R5", {tag, " ", m_eol});
    check(e_eof == 0, "R6", {tag, " ", m_eof});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!pix_valid && !eol && !eof && line_index == 0, "R1",
          $sformatf("reset outputs pv=%0b eol=%0b eof=%0b line=%0d exp all 0",
                    pix_valid, eol, eof, line_index));
    rst_n = 1;
    @(negedge clk);
    // R1 defaults: 6 pixels, 2 lines
    run_line(1, 6, 0, 1, 0, "R1 default line1");
    run_line(1, 6, 1, 2, 0, "R1 default line2");
  endtask

  task automatic t_frame();
    write_cfg(5, 3);
    pulse_frame();
    run_line(1, 5, 0, 1, 0, "R6 frame line1");
    run_line(1, 5, 0, 2, 0, "R6 frame line2");
    run_line(1, 5, 1, 3, 0, "R6 frame line3");
  endtask

  task automatic t_suspend_and_reblank();
    pulse_frame();
    run_line(6, 5, 0, 1, 0, "R2 long hold");
    @(negedge clk);
    line_clk = 1;
    @(negedge clk);
    line_clk = 0;
    begin
      int seen = 0;
      repeat (4) begin
        @(negedge clk);
        if (pix_valid) seen++;
      end
      check(seen == 0, "R2", $sformatf("pv during partial blank act=%0d exp=0", seen));
    end
    run_line(1, 5, 0, 2, 0, "R2 reblank");
  endtask

  task automatic t_ignore();
    run_line(1, 5, 1, 3, B + 2, "R9 poke in read");
    run_line(1, 5, 0, 4, B + 5 + 1, "R9 poke in tail, R6 past total");
  endtask

  task automatic t_config();
    pulse_frame();
    run_line(1, 5, 0, 1, 0, "R7 before write");
    write_cfg(2, 1);
    run_line(1, 5, 0, 2, 0, "R7 after write same frame");
    run_line(1, 5, 1, 3, 0, "R7 old total kept");
    pulse_frame();
    run_line(1, 2, 1, 1, 0, "R7 new totals");
  endtask

  task automatic t_minimum();
    write_cfg(1, 1);
    pulse_frame();
    run_line(1, 1, 1, 1, 0, "R10 single pixel single line");
  endtask

  task automatic t_abort();
    int e_eol = 0;
    write_cfg(5, 3);
    pulse_frame();
    @(negedge clk);
    line_clk = 1;
    @(negedge clk);
    line_clk = 0;
    repeat (B + 2) @(negedge clk);
    check(pix_valid == 1, "R8", $sformatf("pv before abort act=%0b exp=1", pix_valid));
    frame_start = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (eol) e_eol++;
      if (i == 0)
        check(!pix_valid, "R8", $sformatf("pv after abort act=%0b exp=0", pix_valid));
    end
    frame_start = 0;
    repeat (4) begin
      @(negedge clk);
      if (eol || pix_valid) e_eol++;
    end
    check(e_eol == 0, "R8", $sformatf("eol/pv after abort count act=%0d exp=0", e_eol));
    check(line_index == 0, "R8", $sformatf("line after abort act=%0d exp=0", line_index));
    run_line(1, 5, 0, 1, 0, "R8 line after abort");
  endtask

  initial begin
    t_reset();
    t_frame();
    t_suspend_and_reblank();
    t_ignore();
    t_config();
    t_minimum();
    t_abort();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule